// File: doc/BRIEF.md
# Closed-Page Bank Issue Scheduler

This block chooses, once per clock, which bank of a single memory channel may send its head request to the DRAM. Every bank offers a valid flag and a read/write flag for the request at the head of its queue. The queues themselves live outside the block. Under a closed-page policy each issue opens and then closes its bank. The bank therefore stays busy for a fixed time. The shared command/data path is held for a basic time, plus an extra bubble when a write follows a read, or when a read to a different rank follows a read.

Three bus down-counters are loaded according to the type of the request just issued. A per-bank busy counter guards each bank. A round-robin picker starts one bank past the last grant and takes the first bank that every rule allows. Two external mask vectors can hold back individual banks before arbitration: one for request ageing and one for the activate-window limit. The grant is a registered, one-hot pulse that lasts one cycle, and it comes with the read/write flag of the granted request.

Top module: `bank_issue_sched`

## Requirements
- R1: `grant` is registered and at most one bit is set. A bit is set only in the cycle after the same bank showed `req_valid` high. An eligible bank that waits alone is granted one cycle after its request appears.
- R2: Two grants to the same bank are at least BANK_BUSY cycles apart. A bank that keeps requesting with no competition is granted exactly every BANK_BUSY cycles.
- R3: Any two grants are at least BUS_BASIC cycles apart.
- R4: A write granted after a read is at least BUS_BASIC+RD_WR_GAP cycles after it, and exactly that far when the write is waiting. A write after a write needs only BUS_BASIC. `req_write` high means write and low means read, and `grant_write` repeats that flag for the granted request.
- R5: A read after a read to a different rank is at least BUS_BASIC+RANK_GAP cycles after it. A read after a read to the same rank, and a read after a write to any rank, need only BUS_BASIC.
- R6: Arbitration is round-robin. After reset the scan starts at bank 0. After a grant to bank k, the scan starts at bank k+1 and wraps from the last bank to bank 0.
- R7: A bank whose `age_hold` or `window_hold` bit is high is never granted. Once the mask drops, the bank is granted in the next cycle if it is eligible.
- R8: Bank i belongs to rank i / BANKS_PER_RANK (integer division). With the defaults, banks 0 to 3 form rank 0 and banks 4 to 7 form rank 1.
- R9: Synchronous reset clears `grant`, `grant_write`, all busy counters and the last-issued rank (rank 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NB | Head request present, one bit per bank |
| req_write | input | NB | Head request is a write (1) or read (0) |
| age_hold | input | NB | Ageing mask, 1 blocks the bank |
| window_hold | input | NB | Activate-window mask, 1 blocks the bank |
| grant | output | NB | One-hot issue pulse |
| grant_write | output | 1 | Write flag of the granted request |

## Verification
One bank requesting alone shows the bank busy time in isolation. Four reads in one rank show the basic bus spacing and the round-robin order. Pairs that mix read-then-write, write-then-read and read-then-read across the bank 3/bank 4 rank boundary tell the three bubble counters apart, because each pair is limited by exactly one of them. Two sparse banks and a full set of writes show the pointer wrapping, and the mask scenario shows that held banks stay silent until they are released.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  function automatic int rank_of(input int bank_idx, input int banks_per_rank);
    return bank_idx / banks_per_rank;
  endfunction

  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int BANK_BUSY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic idle
);
  localparam int BW = sched_pkg::width_for(BANK_BUSY);
  localparam logic [BW-1:0] RELOAD = BW'(BANK_BUSY - 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - BW'(1);
    end
  end

  assign idle = (cnt == '0);

  // R2: a bank is never loaded again while its busy time is still running
  assert_bank_idle_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));

endmodule

// File: rtl/bus_timers.sv
module bus_timers #(
  parameter int NR        = 2,
  parameter int BUS_BASIC = 2,
  parameter int RD_WR_GAP = 3,
  parameter int RANK_GAP  = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              issue,
  input  logic                              issue_write,
  input  logic [((NR > 1) ? $clog2(NR) : 1)-1:0] issue_rank,
  output logic                              bus_free,
  output logic                              write_ok,
  output logic                              newrank_ok,
  output logic [((NR > 1) ? $clog2(NR) : 1)-1:0] last_rank
);
  localparam int RKW  = (NR > 1) ? $clog2(NR) : 1;
  localparam int MAXB = BUS_BASIC + ((RD_WR_GAP > RANK_GAP) ? RD_WR_GAP : RANK_GAP);
  localparam int CW   = sched_pkg::width_for(MAXB);
  localparam logic [CW-1:0] L_BASIC = CW'(BUS_BASIC - 1);
  localparam logic [CW-1:0] L_RDWR  = CW'(BUS_BASIC + RD_WR_GAP - 1);
  localparam logic [CW-1:0] L_RANK  = CW'(BUS_BASIC + RANK_GAP - 1);

  logic [CW-1:0]  basic_cnt, wr_cnt, rk_cnt;
  logic [RKW-1:0] rank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      basic_cnt <= '0;
      wr_cnt    <= '0;
      rk_cnt    <= '0;
      rank_q    <= '0;
    end else if (issue) begin
      basic_cnt <= L_BASIC;
      wr_cnt    <= issue_write ? L_BASIC : L_RDWR;
      rk_cnt    <= issue_write ? L_BASIC : L_RANK;
      rank_q    <= issue_rank;
    end else begin
      if (basic_cnt != '0) basic_cnt <= basic_cnt - CW'(1);
      if (wr_cnt != '0)    wr_cnt    <= wr_cnt - CW'(1);
      if (rk_cnt != '0)    rk_cnt    <= rk_cnt - CW'(1);
    end
  end

  assign bus_free   = (basic_cnt == '0);
  assign write_ok   = (wr_cnt == '0);
  assign newrank_ok = (rk_cnt == '0);
  assign last_rank  = rank_q;

  // R3: no issue while the basic bus time runs
  assert_bus_free_R3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (basic_cnt == '0));
  // R4: a write only once the read-to-write bubble has passed
  assert_write_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (issue && issue_write) |-> (wr_cnt == '0));
  // R5: a read to another rank only once the rank-switch bubble has passed
  assert_rank_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (issue && !issue_write && (issue_rank != rank_q)) |-> (rk_cnt == '0));

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N-1:0]                    elig,
  output logic                            pick_valid,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] pick_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic          found;
  logic [IW-1:0] sel;

  always_comb begin
    int c;
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(ptr) + k) % N;
      if (!found && elig[c]) begin
        found = 1'b1;
        sel   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= IW'(N - 1);
    end else if (found) begin
      ptr <= sel;
    end
  end

  assign pick_valid = found;
  assign pick_idx   = sel;

  // R6: the picked bank is always one of the eligible banks
  assert_pick_eligible_R6: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> elig[pick_idx]);

endmodule

// File: rtl/bank_issue_sched.sv
module bank_issue_sched #(
  parameter int DIMMS          = 1,
  parameter int RANKS_PER_DIMM = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int BANK_BUSY      = 6,
  parameter int BUS_BASIC      = 2,
  parameter int RD_WR_GAP      = 3,
  parameter int RANK_GAP       = 1,
  localparam int NR = DIMMS * RANKS_PER_DIMM,
  localparam int NB = NR * BANKS_PER_RANK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] req_valid,
  input  logic [NB-1:0] req_write,
  input  logic [NB-1:0] age_hold,
  input  logic [NB-1:0] window_hold,
  output logic [NB-1:0] grant,
  output logic          grant_write
);
  import sched_pkg::*;

  localparam int RKW = (NR > 1) ? $clog2(NR) : 1;
  localparam int IW  = (NB > 1) ? $clog2(NB) : 1;

  logic [NB-1:0]  bank_idle;
  logic [NB-1:0]  elig;
  logic [NB-1:0]  issue_vec;
  logic [RKW-1:0] bank_rank [NB];
  logic           bus_free, write_ok, newrank_ok;
  logic [RKW-1:0] last_rank;
  logic           pick_valid;
  logic [IW-1:0]  pick_idx;
  op_e            pick_op;
  logic [NB-1:0]  grant_q;
  logic           grant_write_q;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam logic [RKW-1:0] MY_RANK = RKW'(rank_of(i, BANKS_PER_RANK));

    bank_timer #(.BANK_BUSY(BANK_BUSY)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .load (issue_vec[i]),
      .idle (bank_idle[i])
    );

    assign bank_rank[i] = MY_RANK;
    assign issue_vec[i] = pick_valid && (pick_idx == IW'(i));

    always_comb begin
      elig[i] = req_valid[i] && bank_idle[i] && !age_hold[i] && !window_hold[i] && bus_free;
      if (req_write[i]) begin
        elig[i] = elig[i] && write_ok;
      end else if (MY_RANK != last_rank) begin
        elig[i] = elig[i] && newrank_ok;
      end
    end

    // R1: a grant bit follows a valid request from the same bank
    assert_grant_valid_R1: assert property (@(posedge clk) disable iff (rst)
      grant_q[i] |-> $past(req_valid[i]));
    // R7: masked banks are never granted
    assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (rst)
      grant_q[i] |-> !$past(age_hold[i] || window_hold[i]));
  end

  rr_picker #(.N(NB)) u_pick (
    .clk        (clk),
    .rst        (rst),
    .elig       (elig),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign pick_op = req_write[pick_idx] ? OP_WRITE : OP_READ;

  bus_timers #(
    .NR        (NR),
    .BUS_BASIC (BUS_BASIC),
    .RD_WR_GAP (RD_WR_GAP),
    .RANK_GAP  (RANK_GAP)
  ) u_bus (
    .clk         (clk),
    .rst         (rst),
    .issue       (pick_valid),
    .issue_write (pick_op == OP_WRITE),
    .issue_rank  (bank_rank[pick_idx]),
    .bus_free    (bus_free),
    .write_ok    (write_ok),
    .newrank_ok  (newrank_ok),
    .last_rank   (last_rank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q       <= '0;
      grant_write_q <= 1'b0;
    end else begin
      grant_q       <= issue_vec;
      grant_write_q <= pick_valid && (pick_op == OP_WRITE);
    end
  end

  assign grant       = grant_q;
  assign grant_write = grant_write_q;

  // R1: grant is one-hot or idle
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  // R9: no write flag without a grant
  assert_write_flag_R9: assert property (@(posedge clk) disable iff (rst)
    grant_write_q |-> (grant_q != '0));

endmodule

// File: tb/tb_bank_issue_sched.sv
module tb_bank_issue_sched;
  localparam int NB    = 8;
  localparam int BUSY  = 6;
  localparam int BASIC = 2;
  localparam int RDWR  = 3;
  localparam int RRG   = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] req_valid = '0, req_write = '0, age_hold = '0, window_hold = '0;
  logic [NB-1:0] grant;
  logic          grant_write;

  int checks = 0, fails = 0, cyc = 0, g_n = 0;
  int g_cyc [64];
  int g_idx [64];
  int g_wr  [64];

  always #2.5 clk = ~clk;

  bank_issue_sched #(
    .DIMMS(1), .RANKS_PER_DIMM(2), .BANKS_PER_RANK(4),
    .BANK_BUSY(BUSY), .BUS_BASIC(BASIC), .RD_WR_GAP(RDWR), .RANK_GAP(RRG)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .age_hold(age_hold), .window_hold(window_hold),
    .grant(grant), .grant_write(grant_write)
  );

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (!rst && grant != '0 && g_n < 64) begin
      for (int k = 0; k < NB; k++) if (grant[k]) g_idx[g_n] = k;
      g_cyc[g_n] = cyc;
      g_wr[g_n]  = grant_write;
      g_n = g_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic need(input int n, input string req);
    chk(g_n >= n, req, g_n, n);
  endtask

  task automatic restart();
    @(negedge clk);
    rst = 1'b1;
    req_valid = '0; req_write = '0; age_hold = '0; window_hold = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    g_n = 0;
  endtask

  task automatic t_reset();
    restart();
    chk(grant == '0, "R9 grant after reset", int'(grant), 0);
    chk(grant_write == 1'b0, "R9 grant_write after reset", int'(grant_write), 0);
  endtask

  task automatic t_single();
    int d;
    restart();
    d = cyc;
    req_valid[0] = 1'b1;
    repeat (14) @(negedge clk);
    need(2, "R2 single bank grants");
    if (g_n >= 2) begin
      chk(g_cyc[0] == d + 1, "R1 first grant latency", g_cyc[0] - d, 1);
      chk(g_idx[0] == 0, "R1 granted bank", g_idx[0], 0);
      chk(g_cyc[1] - g_cyc[0] == BUSY, "R2 same bank spacing", g_cyc[1] - g_cyc[0], BUSY);
    end
  endtask

  task automatic t_same_rank_reads();
    restart();
    req_valid = 8'h0F;
    repeat (10) @(negedge clk);
    need(4, "R3 four reads");
    if (g_n >= 4) begin
      for (int k = 0; k < 4; k++)
        chk(g_idx[k] == k, "R6 scan order from bank 0", g_idx[k], k);
      for (int k = 1; k < 4; k++)
        chk(g_cyc[k] - g_cyc[k-1] == BASIC, "R3 R5 same-rank read spacing",
            g_cyc[k] - g_cyc[k-1], BASIC);
    end
  endtask

  task automatic t_pair(input int a, input bit wa, input int b, input bit wb,
                        input int gap, input string req);
    restart();
    req_valid[a] = 1'b1; req_write[a] = wa;
    req_valid[b] = 1'b1; req_write[b] = wb;
    repeat (8) @(negedge clk);
    need(2, req);
    if (g_n >= 2) begin
      chk(g_idx[0] == a && g_idx[1] == b, req, g_idx[1], b);
      chk(g_cyc[1] - g_cyc[0] == gap, req, g_cyc[1] - g_cyc[0], gap);
      chk(g_wr[0] == int'(wa) && g_wr[1] == int'(wb), {req, " grant_write"}, g_wr[1], int'(wb));
    end
  endtask

  task automatic t_inhibit();
    int d;
    restart();
    req_valid = 8'h03;
    age_hold[0] = 1'b1;
    window_hold[1] = 1'b1;
    repeat (10) @(negedge clk);
    chk(g_n == 0, "R7 masked banks silent", g_n, 0);
    d = cyc;
    age_hold[0] = 1'b0;
    repeat (3) @(negedge clk);
    need(1, "R7 release");
    if (g_n >= 1) begin
      chk(g_idx[0] == 0, "R7 released bank granted", g_idx[0], 0);
      chk(g_cyc[0] == d + 1, "R7 release latency", g_cyc[0] - d, 1);
    end
    req_valid = '0;
    g_n = 0;
    repeat (10) @(negedge clk);
    chk(g_n == 0, "R1 no grant without request", g_n, 0);
  endtask

  task automatic t_wrap();
    int d;
    int exp_i [4] = '{2, 6, 2, 6};
    int exp_c [4] = '{1, 3, 7, 9};
    restart();
    d = cyc;
    req_valid = 8'h44; req_write = 8'h44;
    repeat (11) @(negedge clk);
    need(4, "R6 sparse wrap");
    if (g_n >= 4) begin
      for (int k = 0; k < 4; k++) begin
        chk(g_idx[k] == exp_i[k], "R6 sparse order", g_idx[k], exp_i[k]);
        chk(g_cyc[k] - d == exp_c[k], "R2 R6 sparse timing", g_cyc[k] - d, exp_c[k]);
      end
    end
  endtask

  task automatic t_all_writes();
    restart();
    req_valid = '1; req_write = '1;
    repeat (20) @(negedge clk);
    need(9, "R6 all writes");
    if (g_n >= 9) begin
      for (int k = 0; k < 9; k++) begin
        chk(g_idx[k] == k % NB, "R6 full rotation", g_idx[k], k % NB);
        if (k > 0)
          chk(g_cyc[k] - g_cyc[k-1] == BASIC, "R4 write after write spacing",
              g_cyc[k] - g_cyc[k-1], BASIC);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_same_rank_reads();
    t_pair(0, 1'b0, 1, 1'b1, BASIC + RDWR, "R4 read then write");
    t_pair(0, 1'b1, 4, 1'b0, BASIC, "R5 write then read other rank");
    t_pair(3, 1'b0, 4, 1'b0, BASIC + RRG, "R5 R8 read rank switch 3 to 4");
    t_pair(0, 1'b0, 3, 1'b0, BASIC, "R8 banks 0 and 3 share a rank");
    t_inhibit();
    t_wrap();
    t_all_writes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule